// File: doc/BRIEF.md
# Chip-Select Strobe Timer

This block shapes one peripheral bus access in units of the fast (double-rate) clock it runs on. When a request is accepted it drives chip select low, waits a programmed lead time, then drives a read strobe or the enabled write lane strobes for a programmed width. It releases chip select a programmed trail time after the strobe ends. Reads and writes each have their own lead, width and trail fields, so a slow read path and a fast write path can share one controller.

After chip select rises, it stays high for a fixed recovery of three clocks before the next access may start. A one-clock `done` pulse marks the last recovery clock. The request side is a valid/ready handshake. `req_ready` is high while the block is idle and during the last recovery clock, so a waiting request is taken back to back with no lost clock. While `req_ready` is low, `req_valid` and every configuration input are ignored. The configuration used by an access is the one present on the accepting edge.

Top module: `cs_strobe_timer`

## Requirements
- R1: Lead field value 0, 1 or 2 gives 2, 4 or 6 clocks from chip select assertion to strobe assertion. Value 3 behaves as 2.
- R2: Width field value 0, 1 or 2 keeps the strobe asserted (low) for 2, 4 or 6 clocks. Value 3 behaves as 2.
- R3: Trail field value 1 releases chip select 1 clock after the strobe negates. Values 2 and 3 release it 3 clocks after.
- R4: Trail field value 0 releases chip select one clock before the strobe negates.
- R5: After chip select rises it stays high for exactly 3 clocks before a back-to-back access asserts it again.
- R6: `req_ready` is high when idle and during the last recovery clock, and low otherwise. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `cs_n` goes low in the clock right after the accepting edge.
- R7: `done` is a single-clock pulse in the last recovery clock. The access lasts lead+width+trail+3 clocks, where the trail counts as -1 for field value 0.
- R8: A read (`req_write`=0) uses the read fields and pulses only `rd_n`. A write uses the write fields and pulses only `wr_n`. The fields of the other direction have no effect.
- R9: On a write, `wr_n[i]` pulses exactly when `req_be[i]`=1 (bit 1 is the upper byte lane, bit 0 the lower), and all enabled lanes share identical timing. With no lane enabled, no strobe pulses.
- R10: Changes on the configuration inputs, `req_write` and `req_be` after the accepting edge do not alter the access in progress.
- R11: During and after reset, `cs_n`, `rd_n` and `wr_n` are high and `done` is low. After reset, `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; all timing is counted in its periods |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Request can be accepted this clock |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_be | input | LANES | Byte lane enables for writes, bit 1 upper, bit 0 lower |
| rd_lead | input | 2 | Read lead field (chip select to strobe) |
| rd_width | input | 2 | Read strobe width field |
| rd_trail | input | 2 | Read trail field (strobe end to chip select release) |
| wr_lead | input | 2 | Write lead field |
| wr_width | input | 2 | Write strobe width field |
| wr_trail | input | 2 | Write trail field |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | LANES | Write strobes per byte lane, active low |
| done | output | 1 | One-clock end-of-access pulse |

## Verification
Every result is counted from the accepting edge: clock c = 0 is the first clock after that edge, and the expected level of `cs_n`, `rd_n`, `wr_n`, `done` and `req_ready` is a closed-form function of c and the decoded lead, width and trail. The bench samples every output at the falling edge of each clock c from 0 through the last recovery clock, and once more in the idle clock that follows when no request waits. It sweeps all 64 field combinations for both directions with varied lane enables. Back-to-back requests are held valid from clock 0 onward, so the 3-clock recovery gap and the ignoring of a request while `req_ready` is low are checked in the same cycle-exact way.

// File: rtl/csst_pkg.sv
package csst_pkg;

  // Encoding of the trail field; value 3 is reserved and decodes like value 2.
  typedef enum logic [1:0] {
    TRAIL_EARLY = 2'd0,
    TRAIL_ONE   = 2'd1,
    TRAIL_THREE = 2'd2,
    TRAIL_RSVD  = 2'd3
  } trail_e;

  localparam int unsigned FIELD_W  = 2;
  localparam int unsigned SPAN_MAX = 6;
  localparam int unsigned TAIL_MAX = 3;

  // Lead and width fields: even clock counts, reserved value clamps to the largest.
  function automatic int unsigned span_clks(input logic [FIELD_W-1:0] f);
    case (f)
      2'd0:    return 2;
      2'd1:    return 4;
      default: return 6;
    endcase
  endfunction

endpackage

// File: rtl/csst_timing_decode.sv
module csst_timing_decode
  import csst_pkg::*;
#(
  parameter int unsigned CNT_W    = 5,
  parameter int unsigned REC_CLKS = 3
) (
  input  logic               is_write,
  input  logic [FIELD_W-1:0] rd_lead,
  input  logic [FIELD_W-1:0] rd_width,
  input  logic [FIELD_W-1:0] rd_trail,
  input  logic [FIELD_W-1:0] wr_lead,
  input  logic [FIELD_W-1:0] wr_width,
  input  logic [FIELD_W-1:0] wr_trail,
  output logic [CNT_W-1:0]   lead_clks,
  output logic [CNT_W-1:0]   width_clks,
  output logic [CNT_W-1:0]   cs_len_clks,
  output logic [CNT_W-1:0]   total_clks
);

  logic [FIELD_W-1:0] sel_lead, sel_width;
  trail_e             sel_trail;
  logic [CNT_W-1:0]   body;

  always_comb begin
    sel_lead  = is_write ? wr_lead  : rd_lead;
    sel_width = is_write ? wr_width : rd_width;
    sel_trail = trail_e'(is_write ? wr_trail : rd_trail);
  end

  always_comb begin
    lead_clks  = CNT_W'(span_clks(sel_lead));
    width_clks = CNT_W'(span_clks(sel_width));
    body       = lead_clks + width_clks;
    case (sel_trail)
      TRAIL_EARLY: cs_len_clks = body - CNT_W'(1);
      TRAIL_ONE:   cs_len_clks = body + CNT_W'(1);
      default:     cs_len_clks = body + CNT_W'(TAIL_MAX);
    endcase
    total_clks = cs_len_clks + CNT_W'(REC_CLKS);
  end

endmodule

// File: rtl/csst_sequencer.sv
module csst_sequencer #(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [LANES-1:0] req_be,
  input  logic [CNT_W-1:0] lead_in,
  input  logic [CNT_W-1:0] width_in,
  input  logic [CNT_W-1:0] cs_len_in,
  input  logic [CNT_W-1:0] total_in,
  output logic             req_ready,
  output logic             busy,
  output logic [CNT_W-1:0] cnt,
  output logic             write_q,
  output logic [LANES-1:0] be_q,
  output logic [CNT_W-1:0] lead_q,
  output logic [CNT_W-1:0] width_q,
  output logic [CNT_W-1:0] cs_len_q,
  output logic             done
);

  logic [CNT_W-1:0] total_q;
  logic             last;
  logic             accept;

  assign last      = busy && (cnt == total_q - CNT_W'(1));
  assign req_ready = !busy || last;
  assign accept    = req_valid && req_ready;
  assign done      = last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      write_q  <= 1'b0;
      be_q     <= '0;
      lead_q   <= '0;
      width_q  <= '0;
      cs_len_q <= '0;
      total_q  <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      cnt      <= '0;
      write_q  <= req_write;
      be_q     <= req_be;
      lead_q   <= lead_in;
      width_q  <= width_in;
      cs_len_q <= cs_len_in;
      total_q  <= total_in;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      else      cnt  <= cnt + CNT_W'(1);
    end
  end

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && cnt == '0)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && $stable(total_q) && $stable(be_q))); // R10

endmodule

// File: rtl/csst_pins.sv
module csst_pins #(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic [CNT_W-1:0] cnt,
  input  logic             write_q,
  input  logic [LANES-1:0] be_q,
  input  logic [CNT_W-1:0] lead_q,
  input  logic [CNT_W-1:0] width_q,
  input  logic [CNT_W-1:0] cs_len_q,
  output logic             cs_n,
  output logic             rd_n,
  output logic [LANES-1:0] wr_n
);

  logic strobe_win;
  logic [CNT_W-1:0] strobe_end;

  assign strobe_end = lead_q + width_q;
  assign strobe_win = busy && (cnt >= lead_q) && (cnt < strobe_end);
  assign cs_n       = !(busy && (cnt < cs_len_q));
  assign rd_n       = !(strobe_win && !write_q);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign wr_n[i] = !(strobe_win && write_q && be_q[i]);
  end

  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n) || (wr_n != '1 && $past(wr_n) == '1)) |-> !cs_n); // R1
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && (wr_n != '1))); // R8
  AST_CS_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n ##1 cs_n); // R5

endmodule

// File: rtl/cs_strobe_timer.sv
module cs_strobe_timer
  import csst_pkg::*;
#(
  parameter int unsigned LANES    = 2,
  parameter int unsigned REC_CLKS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [LANES-1:0]   req_be,
  input  logic [FIELD_W-1:0] rd_lead,
  input  logic [FIELD_W-1:0] rd_width,
  input  logic [FIELD_W-1:0] rd_trail,
  input  logic [FIELD_W-1:0] wr_lead,
  input  logic [FIELD_W-1:0] wr_width,
  input  logic [FIELD_W-1:0] wr_trail,
  output logic               cs_n,
  output logic               rd_n,
  output logic [LANES-1:0]   wr_n,
  output logic               done
);

  localparam int unsigned MAX_TOTAL = 2 * SPAN_MAX + TAIL_MAX + REC_CLKS;
  localparam int unsigned CNT_W     = $clog2(MAX_TOTAL + 1);

  logic [CNT_W-1:0] lead_c, width_c, cs_len_c, total_c;
  logic [CNT_W-1:0] cnt, lead_q, width_q, cs_len_q;
  logic             busy, write_q;
  logic [LANES-1:0] be_q;

  csst_timing_decode #(.CNT_W(CNT_W), .REC_CLKS(REC_CLKS)) u_decode (
    .is_write    (req_write),
    .rd_lead     (rd_lead),
    .rd_width    (rd_width),
    .rd_trail    (rd_trail),
    .wr_lead     (wr_lead),
    .wr_width    (wr_width),
    .wr_trail    (wr_trail),
    .lead_clks   (lead_c),
    .width_clks  (width_c),
    .cs_len_clks (cs_len_c),
    .total_clks  (total_c)
  );

  csst_sequencer #(.CNT_W(CNT_W), .LANES(LANES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_be    (req_be),
    .lead_in   (lead_c),
    .width_in  (width_c),
    .cs_len_in (cs_len_c),
    .total_in  (total_c),
    .req_ready (req_ready),
    .busy      (busy),
    .cnt       (cnt),
    .write_q   (write_q),
    .be_q      (be_q),
    .lead_q    (lead_q),
    .width_q   (width_q),
    .cs_len_q  (cs_len_q),
    .done      (done)
  );

  csst_pins #(.CNT_W(CNT_W), .LANES(LANES)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .cnt      (cnt),
    .write_q  (write_q),
    .be_q     (be_q),
    .lead_q   (lead_q),
    .width_q  (width_q),
    .cs_len_q (cs_len_q),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && rd_n && wr_n == '1 && !done)); // R11

endmodule

// File: tb/tb_cs_strobe_timer.sv
module tb_cs_strobe_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [1:0] req_be = 2'b00;
  logic [1:0] rd_lead = '0, rd_width = '0, rd_trail = '0;
  logic [1:0] wr_lead = '0, wr_width = '0, wr_trail = '0;
  logic       cs_n, rd_n, done;
  logic [1:0] wr_n;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  cs_strobe_timer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_be(req_be),
    .rd_lead(rd_lead), .rd_width(rd_width), .rd_trail(rd_trail),
    .wr_lead(wr_lead), .wr_width(wr_width), .wr_trail(wr_trail),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .done(done)
  );

  task automatic chk(input string tag, input string what, input int c,
                     input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s clock %0d: actual %0h expected %0h", tag, what, c, act, exp);
    end
  endtask

  function automatic int span(input int f);
    return (f == 0) ? 2 : (f == 1) ? 4 : 6;
  endfunction

  // Item k: bits 1:0 lead, 3:2 width, 5:4 trail, bit 6 direction.
  function automatic int it_s(input int k); return k & 3; endfunction
  function automatic int it_a(input int k); return (k >> 2) & 3; endfunction
  function automatic int it_h(input int k); return (k >> 4) & 3; endfunction
  function automatic logic it_w(input int k); return k[6]; endfunction
  function automatic logic [1:0] it_be(input int k); return 2'(k * 3 + 1); endfunction
  function automatic bit chained(input int k); return (k % 3) != 0; endfunction

  task automatic drive_item(input int k);
    req_write = it_w(k);
    req_be    = it_be(k);
    // R8: the unused direction's fields get random values and must not matter
    if (it_w(k)) begin
      wr_lead = 2'(it_s(k)); wr_width = 2'(it_a(k)); wr_trail = 2'(it_h(k));
      rd_lead = 2'($urandom); rd_width = 2'($urandom); rd_trail = 2'($urandom);
    end else begin
      rd_lead = 2'(it_s(k)); rd_width = 2'(it_a(k)); rd_trail = 2'(it_h(k));
      wr_lead = 2'($urandom); wr_width = 2'($urandom); wr_trail = 2'($urandom);
    end
  endtask

  task automatic scramble();
    // R10: inputs change after acceptance; the access in flight must not move
    req_write = 1'($urandom); req_be = 2'($urandom);
    rd_lead = 2'($urandom); rd_width = 2'($urandom); rd_trail = 2'($urandom);
    wr_lead = 2'($urandom); wr_width = 2'($urandom); wr_trail = 2'($urandom);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL R6 watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    bit pend;
    pend = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", "cs_n in reset", 0, {3'b0, cs_n}, 4'h1);
    chk("R11", "rd_n in reset", 0, {3'b0, rd_n}, 4'h1);
    chk("R11", "wr_n in reset", 0, {2'b0, wr_n}, 4'h3);
    chk("R11", "done in reset", 0, {3'b0, done}, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "req_ready after reset", 0, {3'b0, req_ready}, 4'h1);
    chk("R11", "cs_n after reset", 0, {3'b0, cs_n}, 4'h1);

    for (int k = 0; k < 128; k++) begin
      int s, a, csl, t;
      logic w;
      logic [1:0] be;
      if (!pend) begin
        drive_item(k);
        req_valid = 1'b1;
      end
      @(posedge clk);
      s  = span(it_s(k));
      a  = span(it_a(k));
      w  = it_w(k);
      be = it_be(k);
      csl = (it_h(k) == 0) ? s + a - 1 : (it_h(k) == 1) ? s + a + 1 : s + a + 3;
      t  = csl + 3;
      for (int c = 0; c < t; c++) begin
        logic strobe;
        logic [1:0] wexp;
        string ctag, stag;
        @(negedge clk);
        strobe = (c >= s) && (c < s + a);
        ctag = (c >= csl) ? "R5" : (it_h(k) == 0) ? "R4" : "R3";
        stag = (c < s) ? "R1" : "R2";
        chk(ctag, "cs_n", c, {3'b0, cs_n}, {3'b0, !(c < csl)});
        chk(w ? "R8" : stag, "rd_n", c, {3'b0, rd_n}, {3'b0, !(strobe && !w)});
        for (int i = 0; i < 2; i++) wexp[i] = !(strobe && w && be[i]);
        chk(w ? "R9" : "R8", "wr_n", c, {2'b0, wr_n}, {2'b0, wexp});
        chk("R7", "done", c, {3'b0, done}, {3'b0, c == t - 1});
        chk("R6", "req_ready", c, {3'b0, req_ready}, {3'b0, c == t - 1});
        if (c == 0) begin
          if (k < 127 && chained(k)) begin
            drive_item(k + 1);   // R6: held valid while not ready is ignored
            req_valid = 1'b1;
          end else begin
            scramble();          // R10
            req_valid = 1'b0;
          end
        end
      end
      pend = (k < 127) && chained(k);
      if (!pend) begin
        @(negedge clk);
        chk("R7", "done after end", 0, {3'b0, done}, 4'h0);
        chk("R5", "cs_n idle", 0, {3'b0, cs_n}, 4'h1);
        chk("R6", "req_ready idle", 0, {3'b0, req_ready}, 4'h1);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule